// File: doc/BRIEF.md
# Distributed Persistent Request Table

Every cache in a token-counting coherence system keeps its own copy of this table. Processors that have failed to gather tokens for a block through ordinary requests broadcast a persistent request. Every node receives the same stream of activate and deactivate messages and runs the same arbitration on it, so all nodes agree on which processor currently owns each contended block. No central arbiter is involved, and a handoff costs one message latency.

The table has one slot per processor, selected by processor number. Each slot holds a valid bit and a block address. The cache controller presents a block address on the lookup port. The table searches all slots by address and returns whether any valid slot matches. When several match, it returns the lowest-numbered matching processor as the winner. It also tells the controller to surrender its tokens when that winner is some other node's processor.

A wave rule keeps a processor that was just served from starving the others. After a processor deactivates an address that other processors still contend for, it may not reissue for that address until no slot names that address any more. The table reports this as a per-processor reissue permission. Messages that break the protocol are still handled deterministically, and each one raises a one-cycle error pulse.

Top module: `prt_table`

## Requirements
- R1: After reset every slot is empty, `lk_hit` is 0, `lk_winner` is 0, `may_reissue` is all ones and `proto_err` is 0.
- R2: An activate (`msg_kind`=1) from processor `msg_src` whose slot is empty, and which is not wave-blocked on `msg_addr`, records `msg_addr` in that slot. From the cycle after the message, a lookup of that address hits.
- R3: A lookup returns `lk_hit`=1 and, as `lk_winner`, the lowest processor number whose valid slot holds `lk_addr`. When no valid slot matches, it returns `lk_hit`=0 and `lk_winner`=0. The lookup is combinational on the stored state.
- R4: A deactivate (`msg_kind`=0) whose address equals the sender's valid stored address empties that slot. From the next cycle, the next-lowest matching processor wins lookups of that address.
- R5: `lk_forward` is 1 exactly when `lk_hit` is 1 and `lk_winner` differs from the parameter `LOCAL_ID`.
- R6: If other valid slots still hold an address after an accepted deactivate of that address, `may_reissue[msg_src]` is 0 from the next cycle.
- R7: A blocked processor's `may_reissue` bit returns to 1 in the cycle after the message that leaves no valid slot holding its blocked address.
- R8: An activate from an empty-slot processor for the address it is blocked on is dropped: the slot stays empty and `proto_err` pulses. An activate for a different address is accepted normally.
- R9: An activate to a slot that is already valid overwrites the stored address and pulses `proto_err`.
- R10: A deactivate to an empty slot, or one whose address differs from the stored one, changes nothing and pulses `proto_err`.
- R11: Messages are applied one per cycle in arrival order. An activate followed on the next cycle by the matching deactivate from the same processor leaves that slot empty.
- R12: `proto_err` is registered. It is 1 only in the cycle after an offending message and 0 after legal messages and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A persistent-request message is present this cycle |
| msg_kind | input | 1 | 1 = activate, 0 = deactivate |
| msg_src | input | PW | Sending processor number |
| msg_addr | input | AW | Block address carried by the message |
| lk_addr | input | AW | Block address looked up by the cache controller |
| lk_hit | output | 1 | Some valid slot holds `lk_addr` |
| lk_winner | output | PW | Lowest matching processor number, 0 on a miss |
| lk_forward | output | 1 | Tokens for `lk_addr` must go to the winner |
| may_reissue | output | NPROC | Bit p is 1 when processor p is not wave-blocked |
| proto_err | output | 1 | One-cycle pulse after a protocol-violating message |

## Verification
The bench goes after priority when several processors contend for one address. A design with the priority reversed or a stale winner would keep naming a processor that has already left, and other caches would keep forwarding tokens to it. It drains waves one deactivate at a time. A design that frees the blocked processors one cycle late, or on the first deactivate instead of the last, would show the wrong reissue bits at that boundary. It also sends each kind of illegal message: a blocked reissue, a double activate, and a deactivate that is stray or carries the wrong address. A design that mishandles one would corrupt a slot or lose the error pulse. A long pseudo-random message stream then compares every lookup address against an arithmetic model of the table.

// File: rtl/prt_pkg.sv
package prt_pkg;
   typedef enum logic {
      PRT_DEACT = 1'b0,
      PRT_ACT   = 1'b1
   } prt_kind_e;
endpackage

// File: rtl/prt_slot.sv
module prt_slot #(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic          clr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] lk_addr_i,
   output logic          valid_o,
   output logic [AW-1:0] addr_o,
   output logic          valid_n_o,
   output logic [AW-1:0] addr_n_o,
   output logic          lk_match_o
);
   logic          valid_q;
   logic [AW-1:0] addr_q;

   always_comb begin
      valid_n_o = valid_q;
      addr_n_o  = addr_q;
      if (set_i) begin
         valid_n_o = 1'b1;
         addr_n_o  = addr_i;
      end else if (clr_i) begin
         valid_n_o = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
      end else begin
         valid_q <= valid_n_o;
         addr_q  <= addr_n_o;
      end
   end

   assign valid_o    = valid_q;
   assign addr_o     = addr_q;
   assign lk_match_o = valid_q && (addr_q == lk_addr_i);

   // R2: an accepted activate leaves the slot valid with the sent address
   a_r2_set_records: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (valid_o && addr_o == $past(addr_i)));
   // R4: an accepted deactivate empties the slot
   a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !valid_o);
   // R11: one message per cycle, so a slot is never set and cleared together
   a_r11_single_op: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_i && clr_i));
endmodule

// File: rtl/prt_wave.sv
module prt_wave #(
   parameter int NPROC = 4,
   parameter int AW    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                deact_i,
   input  logic [AW-1:0]       deact_addr_i,
   input  logic [NPROC-1:0]    valid_n_i,
   input  logic [NPROC*AW-1:0] addr_n_i,
   output logic                blocked_o,
   output logic [AW-1:0]       blk_addr_o
);
   logic          blocked_q;
   logic [AW-1:0] blk_addr_q;
   logic [AW-1:0] watch_addr;
   logic          live;

   assign watch_addr = deact_i ? deact_addr_i : blk_addr_q;

   always_comb begin
      live = 1'b0;
      for (int q = 0; q < NPROC; q++) begin
         if (valid_n_i[q] && addr_n_i[q*AW +: AW] == watch_addr) live = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blocked_q  <= 1'b0;
         blk_addr_q <= '0;
      end else begin
         blocked_q  <= (deact_i || blocked_q) && live;
         blk_addr_q <= watch_addr;
      end
   end

   assign blocked_o  = blocked_q;
   assign blk_addr_o = blk_addr_q;

   // R6: leaving while others still contend blocks the leaver
   a_r6_block_on_leave: assert property (@(posedge clk) disable iff (!rst_n)
      (deact_i && live) |=> blocked_o);
   // R7: a block never appears without a deactivate
   a_r7_no_spurious_block: assert property (@(posedge clk) disable iff (!rst_n)
      (!blocked_o && !deact_i) |=> !blocked_o);
endmodule

// File: rtl/prt_pick.sv
module prt_pick #(
   parameter int NPROC = 4,
   parameter int PW    = 2
) (
   input  logic [NPROC-1:0] req_i,
   output logic             hit_o,
   output logic [PW-1:0]    idx_o
);
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = NPROC - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            hit_o = 1'b1;
            idx_o = PW'(i);
         end
      end
   end
endmodule

// File: rtl/prt_table.sv
module prt_table #(
   parameter int NPROC    = 4,
   parameter int AW       = 8,
   parameter int LOCAL_ID = 0,
   parameter bit LK_REG   = 1'b0,
   localparam int PW      = (NPROC > 1) ? $clog2(NPROC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msg_valid,
   input  logic             msg_kind,
   input  logic [PW-1:0]    msg_src,
   input  logic [AW-1:0]    msg_addr,
   input  logic [AW-1:0]    lk_addr,
   output logic             lk_hit,
   output logic [PW-1:0]    lk_winner,
   output logic             lk_forward,
   output logic [NPROC-1:0] may_reissue,
   output logic             proto_err
);
   import prt_pkg::*;

   if (NPROC < 2) begin : g_bad_nproc
      $error("prt_table: NPROC must be at least 2");
   end
   if (AW < 1) begin : g_bad_aw
      $error("prt_table: AW must be at least 1");
   end
   if (LOCAL_ID < 0 || LOCAL_ID >= NPROC) begin : g_bad_local
      $error("prt_table: LOCAL_ID out of range");
   end

   logic                src_ok;
   logic                is_act;
   logic [NPROC-1:0]    sel;
   logic [NPROC-1:0]    e_valid;
   logic [NPROC-1:0]    e_valid_n;
   logic [NPROC*AW-1:0] e_addr;
   logic [NPROC*AW-1:0] e_addr_n;
   logic [NPROC-1:0]    lk_match;
   logic [NPROC-1:0]    blocked;
   logic [NPROC*AW-1:0] blk_addr;
   logic [NPROC-1:0]    blk_same;
   logic [NPROC-1:0]    deact_ok;
   logic [NPROC-1:0]    set_v;
   logic [NPROC-1:0]    clr_v;
   logic                err_n;
   logic                err_q;
   logic                pick_hit;
   logic [PW-1:0]       pick_idx;

   if ((1 << PW) == NPROC) begin : g_src_full
      assign src_ok = msg_valid;
   end else begin : g_src_cmp
      assign src_ok = msg_valid && (int'(msg_src) < NPROC);
   end

   assign is_act = (prt_kind_e'(msg_kind) == PRT_ACT);

   for (genvar i = 0; i < NPROC; i++) begin : g_proc
      assign sel[i]      = src_ok && (msg_src == PW'(i));
      assign blk_same[i] = blocked[i] && (blk_addr[i*AW +: AW] == msg_addr);
      assign deact_ok[i] = e_valid[i] && (e_addr[i*AW +: AW] == msg_addr);
      assign set_v[i]    = sel[i] && is_act && (e_valid[i] || !blk_same[i]);
      assign clr_v[i]    = sel[i] && !is_act && deact_ok[i];

      prt_slot #(.AW(AW)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .set_i      (set_v[i]),
         .clr_i      (clr_v[i]),
         .addr_i     (msg_addr),
         .lk_addr_i  (lk_addr),
         .valid_o    (e_valid[i]),
         .addr_o     (e_addr[i*AW +: AW]),
         .valid_n_o  (e_valid_n[i]),
         .addr_n_o   (e_addr_n[i*AW +: AW]),
         .lk_match_o (lk_match[i])
      );

      prt_wave #(.NPROC(NPROC), .AW(AW)) u_wave (
         .clk          (clk),
         .rst_n        (rst_n),
         .deact_i      (clr_v[i]),
         .deact_addr_i (msg_addr),
         .valid_n_i    (e_valid_n),
         .addr_n_i     (e_addr_n),
         .blocked_o    (blocked[i]),
         .blk_addr_o   (blk_addr[i*AW +: AW])
      );

      assign may_reissue[i] = !blocked[i];
   end

   always_comb begin
      err_n = msg_valid && !src_ok;
      for (int i = 0; i < NPROC; i++) begin
         if (sel[i]) begin
            if (is_act) begin
               if (e_valid[i] || blk_same[i]) err_n = 1'b1;
            end else if (!deact_ok[i]) begin
               err_n = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_n;
   end
   assign proto_err = err_q;

   prt_pick #(.NPROC(NPROC), .PW(PW)) u_pick (
      .req_i (lk_match),
      .hit_o (pick_hit),
      .idx_o (pick_idx)
   );

   if (LK_REG) begin : g_lk_reg
      logic          hit_q;
      logic [PW-1:0] win_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hit_q <= 1'b0;
            win_q <= '0;
         end else begin
            hit_q <= pick_hit;
            win_q <= pick_idx;
         end
      end
      assign lk_hit    = hit_q;
      assign lk_winner = win_q;
   end else begin : g_lk_comb
      assign lk_hit    = pick_hit;
      assign lk_winner = pick_idx;

      // R3: the reported winner really holds the looked-up address
      a_r3_winner_matches: assert property (@(posedge clk) disable iff (!rst_n)
         lk_hit |-> lk_match[lk_winner]);
      // R3: no lower-numbered processor also matches
      a_r3_winner_lowest: assert property (@(posedge clk) disable iff (!rst_n)
         lk_hit |-> ((lk_match & ((NPROC'(1) << lk_winner) - NPROC'(1))) == '0));
   end

   assign lk_forward = lk_hit && (lk_winner != PW'(LOCAL_ID));

   // R12: an error pulse always follows some message
   a_r12_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> $past(msg_valid));
   // R8: a blocked reissue into an empty slot leaves it empty
   a_r8_blocked_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ok && is_act && !e_valid[msg_src] && blk_same[msg_src])
         |=> (!e_valid[$past(msg_src)] && proto_err));

   for (genvar p = 0; p < NPROC; p++) begin : g_chk
      logic live_now;
      always_comb begin
         live_now = 1'b0;
         for (int q = 0; q < NPROC; q++) begin
            if (e_valid[q] && e_addr[q*AW +: AW] == blk_addr[p*AW +: AW]) live_now = 1'b1;
         end
      end
      // R7: a processor is only blocked while its wave is still live
      a_r7_block_needs_wave: assert property (@(posedge clk) disable iff (!rst_n)
         blocked[p] |-> live_now);
   end
endmodule

// File: tb/tb_prt_table.sv
module tb_prt_table;
   localparam int NP = 4;
   localparam int AW = 8;
   localparam int LID = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          msg_valid = 1'b0;
   logic          msg_kind = 1'b0;
   logic [1:0]    msg_src = '0;
   logic [AW-1:0] msg_addr = '0;
   logic [AW-1:0] lk_addr = '0;
   logic          lk_hit;
   logic [1:0]    lk_winner;
   logic          lk_forward;
   logic [NP-1:0] may_reissue;
   logic          proto_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic          m_vld [NP];
   logic [AW-1:0] m_addr[NP];
   logic          m_blk [NP];
   logic [AW-1:0] m_baddr[NP];
   logic          m_err;

   always #5 clk = ~clk;

   prt_table #(.NPROC(NP), .AW(AW), .LOCAL_ID(LID)) dut (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
      .msg_src(msg_src), .msg_addr(msg_addr), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_winner(lk_winner), .lk_forward(lk_forward),
      .may_reissue(may_reissue), .proto_err(proto_err)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int p = 0; p < NP; p++) begin
         m_vld[p] = 1'b0; m_addr[p] = '0; m_blk[p] = 1'b0; m_baddr[p] = '0;
      end
      m_err = 1'b0;
   endtask

   task automatic model_apply(bit kind, int src, logic [AW-1:0] a);
      bit left;
      logic          nb;
      logic [AW-1:0] na;
      bit live;
      left  = 1'b0;
      m_err = 1'b0;
      if (kind) begin
         if (m_vld[src]) begin m_addr[src] = a; m_err = 1'b1; end
         else if (m_blk[src] && m_baddr[src] == a) m_err = 1'b1;
         else begin m_vld[src] = 1'b1; m_addr[src] = a; end
      end else begin
         if (m_vld[src] && m_addr[src] == a) begin m_vld[src] = 1'b0; left = 1'b1; end
         else m_err = 1'b1;
      end
      for (int p = 0; p < NP; p++) begin
         nb = (left && p == src) ? 1'b1 : m_blk[p];
         na = (left && p == src) ? a : m_baddr[p];
         live = 1'b0;
         for (int q = 0; q < NP; q++) if (m_vld[q] && m_addr[q] == na) live = 1'b1;
         m_blk[p]   = nb && live;
         m_baddr[p] = na;
      end
   endtask

   task automatic check_all(string tag);
      int ew;
      bit eh;
      chk(tag, "proto_err", proto_err, m_err);
      for (int p = 0; p < NP; p++) chk(tag, $sformatf("may_reissue[%0d]", p), may_reissue[p], !m_blk[p]);
      for (int a = 0; a < 4; a++) begin
         lk_addr = AW'(8'h10 + a);
         #1;
         eh = 1'b0; ew = 0;
         for (int p = NP - 1; p >= 0; p--) if (m_vld[p] && m_addr[p] == lk_addr) begin eh = 1'b1; ew = p; end
         chk(tag, $sformatf("lk_hit @%0h", lk_addr), lk_hit, eh);
         chk(tag, $sformatf("lk_winner @%0h", lk_addr), lk_winner, ew);
         chk("R5", $sformatf("lk_forward @%0h", lk_addr), lk_forward, eh && ew != LID);
      end
   endtask

   task automatic send(string tag, bit kind, int src, int a);
      @(negedge clk);
      msg_valid = 1'b1; msg_kind = kind; msg_src = 2'(src); msg_addr = AW'(a);
      @(posedge clk);
      model_apply(kind, src, AW'(a));
      @(negedge clk);
      msg_valid = 1'b0;
      check_all(tag);
   endtask

   initial begin
      logic [15:0] lfsr;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");

      send("R2", 1, 3, 'h10);
      send("R3", 1, 1, 'h10);
      send("R3", 1, 2, 'h10);
      send("R4", 0, 1, 'h10);
      send("R6", 1, 0, 'h11);
      send("R8", 1, 1, 'h10);
      send("R8", 1, 1, 'h12);
      send("R7", 0, 2, 'h10);
      send("R7", 0, 3, 'h10);
      send("R9", 1, 1, 'h13);
      send("R10", 0, 3, 'h13);
      send("R10", 0, 1, 'h12);
      send("R4", 0, 1, 'h13);
      send("R12", 0, 0, 'h11);

      // R11: back-to-back activate then deactivate from the same processor
      @(negedge clk);
      msg_valid = 1'b1; msg_kind = 1'b1; msg_src = 2'd0; msg_addr = 8'h12;
      @(posedge clk);
      model_apply(1'b1, 0, 8'h12);
      @(negedge clk);
      msg_kind = 1'b0;
      @(posedge clk);
      model_apply(1'b0, 0, 8'h12);
      @(negedge clk);
      msg_valid = 1'b0;
      check_all("R11");
      @(negedge clk);
      m_err = 1'b0;
      check_all("R12");

      lfsr = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send("R3", lfsr[0] | lfsr[5], int'(lfsr[2:1]), 'h10 + int'(lfsr[4:3]));
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule